// File: doc/BRIEF.md
# Memory Refresh Register Counter

This block holds the 8-bit refresh register of an 8-bit microprocessor core. The fetch sequencer pulses a strobe once for every opcode fetch that counts, and each pulse advances the register. Prefix bytes count as separate fetches. A two-byte prefixed instruction therefore produces two strobes, and an indexed bit/rotate instruction also produces exactly two. A repeating block transfer produces two strobes per pass. Deciding which fetches count is the sequencer's job. This block only counts the strobes it receives.

Only the seven low bits count, and they wrap from 127 back to 0 without touching bit 7. Bit 7 keeps the value of the most recent load. The load path copies the accumulator into the register, and it writes all 8 bits. The register value also drives a 7-bit refresh address.

For the accumulator read path, the block also forms the flag byte that such a read produces. Sign and bits 5 and 3 come from the value. Zero is set when the value is zero. Parity/overflow carries the second interrupt-enable flip-flop. Half-carry and subtract are cleared, and carry passes through unchanged.

Top module: `refresh_reg`

## Requirements
- R1: While reset is low on a clock edge, all 8 bits of the register become 0.
- R2: A fetch strobe without a load advances bits 6:0 by one, and the new value appears on `value_o` after that clock edge.
- R3: Strobes on consecutive cycles each count, so two strobes (a prefixed or indexed bit/rotate instruction) add 2 and a block transfer of N passes, at 2N strobes, adds 2N.
- R4: Counting wraps bits 6:0 from 127 to 0, and no carry ever reaches bit 7.
- R5: Bit 7 does not change on any cycle without a load.
- R6: A load strobe writes all 8 bits of `load_data_i`, including bit 7, and the new value appears after that clock edge.
- R7: When load and fetch strobes arrive in the same cycle, the loaded value is stored unmodified and the fetch is lost.
- R8: With neither strobe active, the register holds its value.
- R9: `refresh_addr_o` always equals bits 6:0 of `value_o`.
- R10: `read_flags_o` is built from the current value as follows. Bit 7 is value bit 7. Bit 6 is 1 exactly when the value is 0. Bit 5 is value bit 5, and bit 3 is value bit 3. Bits 4 and 1 are 0. Bit 2 equals `iff2_i`, and bit 0 equals `carry_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_i | input | 1 | One pulse per counted opcode fetch |
| load_i | input | 1 | Load strobe from the accumulator |
| load_data_i | input | 8 | Accumulator value to load |
| iff2_i | input | 1 | Second interrupt-enable flip-flop |
| carry_i | input | 1 | Current carry flag, passed through |
| value_o | output | 8 | Current register value |
| refresh_addr_o | output | 7 | Refresh address (low 7 bits) |
| read_flags_o | output | 8 | Flag byte produced by reading the register |

## Verification
The bench builds the block with its default parameters: an 8-bit register whose low 7 bits count. That counting field is small enough for the bench to drive the 127-to-0 wrap within a few hundred cycles. Loads with bit 7 set and with bit 7 clear show that the wrap leaves the top bit alone. A behavioural model kept as an integer predicts the value, the refresh address and the read flags every cycle. Mixed stretches of strobes, loads and simultaneous load-plus-fetch cycles exercise every branch of the next-value choice.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
    // bit positions of the flag byte produced on a register read
    localparam int FLG_SIGN  = 7;
    localparam int FLG_ZERO  = 6;
    localparam int FLG_B5    = 5;
    localparam int FLG_HALF  = 4;
    localparam int FLG_B3    = 3;
    localparam int FLG_PV    = 2;
    localparam int FLG_SUB   = 1;
    localparam int FLG_CARRY = 0;
    localparam int FLG_W     = 8;
endpackage

// File: rtl/refresh_ctr_core.sv
module refresh_ctr_core #(
    parameter int WIDTH = 8,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fetch_i,
    input  logic             load_i,
    input  logic [WIDTH-1:0] load_data_i,
    output logic [WIDTH-1:0] value_o
);
    localparam int HOLD_W = WIDTH - CNT_W;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [HOLD_W-1:0] hold;
        logic [CNT_W-1:0]  cnt;
    } ctr_state_t;

    ctr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d = ctr_state_t'(load_data_i);
        end else if (fetch_i) begin
            st_d.cnt = st_q.cnt + CNT_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign value_o = st_q;
endmodule

// File: rtl/refresh_read_flags.sv
module refresh_read_flags
    import refresh_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] value_i,
    input  logic             iff2_i,
    input  logic             carry_i,
    output logic [FLG_W-1:0] flags_o
);
    always_comb begin
        flags_o            = '0;
        flags_o[FLG_SIGN]  = value_i[WIDTH-1];
        flags_o[FLG_ZERO]  = (value_i == '0);
        flags_o[FLG_B5]    = value_i[5];
        flags_o[FLG_HALF]  = 1'b0;
        flags_o[FLG_B3]    = value_i[3];
        flags_o[FLG_PV]    = iff2_i;
        flags_o[FLG_SUB]   = 1'b0;
        flags_o[FLG_CARRY] = carry_i;
    end
endmodule

// File: rtl/refresh_reg.sv
module refresh_reg #(
    parameter int WIDTH = 8,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fetch_i,
    input  logic             load_i,
    input  logic [WIDTH-1:0] load_data_i,
    input  logic             iff2_i,
    input  logic             carry_i,
    output logic [WIDTH-1:0] value_o,
    output logic [CNT_W-1:0] refresh_addr_o,
    output logic [7:0]       read_flags_o
);
    logic [WIDTH-1:0] value_w;

    refresh_ctr_core #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_i     (fetch_i),
        .load_i      (load_i),
        .load_data_i (load_data_i),
        .value_o     (value_w)
    );

    refresh_read_flags #(.WIDTH(WIDTH)) u_flags (
        .value_i (value_w),
        .iff2_i  (iff2_i),
        .carry_i (carry_i),
        .flags_o (read_flags_o)
    );

    assign value_o        = value_w;
    assign refresh_addr_o = value_w[CNT_W-1:0];
endmodule

// File: rtl/refresh_reg_chk.sv
module refresh_reg_chk #(
    parameter int WIDTH = 8,
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fetch_i,
    input logic             load_i,
    input logic [WIDTH-1:0] load_data_i,
    input logic             iff2_i,
    input logic             carry_i,
    input logic [WIDTH-1:0] value_o,
    input logic [CNT_W-1:0] refresh_addr_o,
    input logic [7:0]       read_flags_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> value_o == '0);

    a_r2_fetch_step: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_i && !load_i) |=> value_o[CNT_W-1:0] == $past(value_o[CNT_W-1:0]) + ONE);

    a_r5_top_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> value_o[WIDTH-1:CNT_W] == $past(value_o[WIDTH-1:CNT_W]));

    a_r6_load_all: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> value_o == $past(load_data_i));

    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !fetch_i) |=> $stable(value_o));

    always_comb begin
        a_r9_addr_low: assert (refresh_addr_o == value_o[CNT_W-1:0]);
        a_r10_flag_pv: assert (read_flags_o[2] == iff2_i && read_flags_o[0] == carry_i);
        a_r10_flag_sign: assert (read_flags_o[7] == value_o[WIDTH-1]);
    end
endmodule

bind refresh_reg refresh_reg_chk #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .fetch_i        (fetch_i),
    .load_i         (load_i),
    .load_data_i    (load_data_i),
    .iff2_i         (iff2_i),
    .carry_i        (carry_i),
    .value_o        (value_o),
    .refresh_addr_o (refresh_addr_o),
    .read_flags_o   (read_flags_o)
);

// File: tb/sim_refresh_reg.sv
`timescale 1ns/1ps
module sim_refresh_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fetch_i = 1'b0;
    logic       load_i = 1'b0;
    logic [7:0] load_data_i = 8'h00;
    logic       iff2_i = 1'b0;
    logic       carry_i = 1'b0;
    logic [7:0] value_o;
    logic [6:0] refresh_addr_o;
    logic [7:0] read_flags_o;

    int errors = 0;
    int checks = 0;
    int model = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    refresh_reg u0 (
        .clk(clk), .rst_n(rst_n), .fetch_i(fetch_i), .load_i(load_i),
        .load_data_i(load_data_i), .iff2_i(iff2_i), .carry_i(carry_i),
        .value_o(value_o), .refresh_addr_o(refresh_addr_o),
        .read_flags_o(read_flags_o)
    );

    function automatic int exp_flags(int v, bit pv, bit c);
        int f;
        f = v & 8'hA8;
        if (v == 0) f = f | 8'h40;
        if (pv) f = f | 8'h04;
        if (c) f = f | 8'h01;
        return f;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all(string tag);
        check(tag, int'(value_o), model);
        check("R9", int'(refresh_addr_o), model & 127);
        check("R10", int'(read_flags_o), exp_flags(model, iff2_i, carry_i));
    endtask

    // one cycle: drive at negedge, update model at posedge, compare at next negedge
    task automatic step(bit f, bit l, int d, string tag);
        fetch_i = f;
        load_i = l;
        load_data_i = d[7:0];
        @(posedge clk);
        if (!rst_n) model = 0;
        else if (l) model = d & 255;
        else if (f) model = (model & 128) | ((model + 1) & 127);
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step(0, 0, 0, "R1");
        step(1, 1, 8'h55, "R1");
        rst_n = 1'b1;
        step(0, 0, 0, "R8");
        // single counted fetch
        step(1, 0, 0, "R2");
        // prefixed instruction: two strobes add 2
        step(1, 0, 0, "R3");
        step(1, 0, 0, "R3");
        check("R3", int'(value_o), 3);
        // block transfer of 5 passes: 10 strobes
        for (int i = 0; i < 10; i++) step(1, 0, 0, "R3");
        check("R3", int'(value_o), 13);
        step(0, 0, 0, "R8");
        // wrap with bit 7 clear
        step(0, 1, 8'h7E, "R6");
        step(1, 0, 0, "R2");
        step(1, 0, 0, "R4");
        check("R4", int'(value_o), 0);
        // wrap with bit 7 set
        step(0, 1, 8'hFF, "R6");
        iff2_i = 1'b1;
        step(1, 0, 0, "R4");
        check("R5", int'(value_o), 8'h80);
        // full lap keeps bit 7
        for (int i = 0; i < 128; i++) step(1, 0, 0, "R5");
        check("R5", int'(value_o), 8'h80);
        // load and fetch together
        step(1, 1, 8'h2A, "R7");
        check("R7", int'(value_o), 8'h2A);
        step(1, 1, 8'h00, "R7");
        carry_i = 1'b1;
        step(0, 0, 0, "R10");
        check("R10", int'(read_flags_o), 8'h45);
        iff2_i = 1'b0;
        step(0, 1, 8'hA8, "R10");
        check("R10", int'(read_flags_o), 8'hA9);
        // mixed stretch
        for (int i = 0; i < 400; i++) begin
            int r;
            r = $urandom;
            iff2_i = r[10];
            carry_i = r[11];
            step(r[0] | r[1], r[2] & r[3] & r[4], (r >> 16) & 255, "R8");
        end
        // reset mid-run
        rst_n = 1'b0;
        step(1, 0, 0, "R1");
        rst_n = 1'b1;
        step(0, 0, 0, "R1");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule